// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Line Controller

This block keeps one write-back cache coherent with the other caches on a shared snooping bus. It holds a small direct-mapped array of tags and line states, and each line is Invalid, Shared (clean and readable) or Exclusive (the only copy, dirty and writable). Requests arrive from two sides. The local processor issues reads and writes. The bus presents read-miss and write-miss transactions from other caches, and this block watches them.

A processor request that the line can serve completes in the cycle it is presented. Any other request is turned into one or two bus transactions, a write-back of a dirty victim and then a read miss or write miss. Each transaction is requested with `bus_req` and is issued in the cycle the arbiter grants it. The processor is held off until the line can serve the request. When a snooped transaction finds the line Exclusive, the block raises a flag so that memory drops its own data response and takes the dirty block instead. The data array and memory live outside this block. Addresses are block addresses: the low bits select the set and the remaining bits form the tag.

Top module: `snoop_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. No processor access hits, `bus_req` is low while `cpu_req` is low, `bus_cmd` reads 0 (idle) and `snp_supply` is low.
- R2: A read whose tag matches a Shared or Exclusive line, and a write whose tag matches an Exclusive line, raise `cpu_ready` in the same cycle with `bus_req` low. The line state does not change.
- R3: A read that misses, with no dirty victim, requests a read miss (`bus_cmd` = 1) at `bus_addr` = `cpu_addr`. After the granted edge the line holds the new tag in Shared, so the request completes one cycle later.
- R4: A write to a line that is not Exclusive with a matching tag requests a write miss (`bus_cmd` = 2). This includes a Shared line whose tag matches. After the granted edge the line is Exclusive with the new tag.
- R5: A read or write whose set holds an Exclusive line with another tag first requests a write-back (`bus_cmd` = 3) at the victim address {old tag, set}. After that grant it requests the read or write miss as in R3 and R4.
- R6: Until its grant, a pending request keeps `bus_req`, `bus_cmd` and `bus_addr` steady and keeps `cpu_ready` low. `cpu_ready` and `bus_req` are never high together.
- R7: A snooped read miss (`snp_wr` = 0) whose tag matches an Exclusive line raises `snp_supply` in that cycle, and the line becomes Shared.
- R8: A snooped write miss (`snp_wr` = 1) whose tag matches a valid line invalidates it. If the line was Exclusive, `snp_supply` is raised in that cycle.
- R9: A snoop that matches no valid line, or a snooped read miss that finds the line Shared, leaves `snp_supply` low and the line unchanged.
- R10: In a cycle with `snp_vld` high, the block ignores `bus_gnt` and holds `cpu_ready` low. In the next cycle the pending request is worked out again from the state the snoop left, so a write-back whose victim the snoop removed is no longer requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request valid, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Processor block address (low IDX_W bits select the set) |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 0 idle, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | AW | Address of the requested transaction |
| bus_gnt | input | 1 | Arbiter grant; the transaction is issued at this edge |
| snp_vld | input | 1 | Another cache's transaction is on the bus |
| snp_wr | input | 1 | Snooped kind: 1 = write miss, 0 = read miss |
| snp_addr | input | AW | Snooped block address |
| snp_supply | output | 1 | This cache owns the dirty block; memory cancels its data response |

## Verification
The bound checker checks, on every cycle, that a completion and a bus request never coincide, that a pending request holds steady until its grant, that snoop cycles never complete a processor access, and that a granted miss or write-back leads to the expected follow-up in the next cycle. Which state a line actually holds after a mixed history of processor and snooped traffic can only be shown by the bench. It sweeps every starting state against every processor and snoop operation on matching and conflicting tags, then runs a long pseudo-random mix. After each operation it probes every address to recover the Invalid, Shared or Exclusive state through the processor port, without changing it.

// File: rtl/snoop_pkg.sv
// Shared types for the snooping line controller.
// Assumes: the bus command encoding is fixed, because the bus and memory decode it.
package snoop_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        BC_IDLE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WBACK  = 2'd3
    } bus_cmd_t;

endpackage

// File: rtl/snoop_line_store.sv
// Tag and state array: one entry per set, two combinational read ports and one write port.
// Assumes: the caller never asks for two updates in the same cycle.
module snoop_line_store
    import snoop_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    output line_st_t         ra_st,
    output logic [TAG_W-1:0] ra_tag,
    input  logic [IDX_W-1:0] rb_idx,
    output line_st_t         rb_st,
    output logic [TAG_W-1:0] rb_tag,
    input  logic             w_en,
    input  logic [IDX_W-1:0] w_idx,
    input  line_st_t         w_st,
    input  logic             w_tag_en,
    input  logic [TAG_W-1:0] w_tag
);
    localparam int SETS = 1 << IDX_W;

    line_st_t         st_q  [SETS];
    logic [TAG_W-1:0] tag_q [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        // Update one set's state and tag; reset leaves it Invalid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[s]  <= LN_INV;
                tag_q[s] <= '0;
            end else if (w_en && (w_idx == IDX_W'(s))) begin
                st_q[s] <= w_st;
                if (w_tag_en) begin
                    tag_q[s] <= w_tag;
                end
            end
        end
    end

    // Read port A serves the processor side.
    always_comb begin
        ra_st  = st_q[ra_idx];
        ra_tag = tag_q[ra_idx];
    end

    // Read port B serves the snoop side.
    always_comb begin
        rb_st  = st_q[rb_idx];
        rb_tag = tag_q[rb_idx];
    end

endmodule

// File: rtl/snoop_cpu_side.sv
// Processor side: classifies the request against the addressed line and chooses the
// bus transaction it needs next (write-back of a dirty victim, read miss or write miss).
// Assumes: the request stays stable until completion; a snoop cycle blocks any issue.
module snoop_cpu_side
    import snoop_pkg::*;
#(
    parameter int AW    = 8,
    parameter int IDX_W = 2
) (
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [AW-1:0]    cpu_addr,
    input  line_st_t         line_st,
    input  logic [AW-IDX_W-1:0] line_tag,
    input  logic             snp_vld,
    input  logic             bus_gnt,
    output logic             cpu_ready,
    output logic             bus_req,
    output bus_cmd_t         bus_cmd,
    output logic [AW-1:0]    bus_addr,
    output logic             fire,
    output line_st_t         upd_st,
    output logic             upd_tag_en
);
    localparam int TAG_W = AW - IDX_W;

    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx;
    logic             tag_eq;
    logic             serve;
    logic             victim_dirty;

    // Split the address and decide whether the line can serve the request locally.
    always_comb begin
        req_tag      = cpu_addr[AW-1:IDX_W];
        req_idx      = cpu_addr[IDX_W-1:0];
        tag_eq       = (line_tag == req_tag);
        if (cpu_we) begin
            serve = (line_st == LN_EXC) && tag_eq;
        end else begin
            serve = (line_st != LN_INV) && tag_eq;
        end
        victim_dirty = (line_st == LN_EXC) && !tag_eq;
    end

    // Choose the next transaction and its address; report completion.
    always_comb begin
        cpu_ready = cpu_req && serve && !snp_vld;
        bus_req   = cpu_req && !serve;
        if (!bus_req) begin
            bus_cmd = BC_IDLE;
        end else if (victim_dirty) begin
            bus_cmd = BC_WBACK;
        end else if (cpu_we) begin
            bus_cmd = BC_WRMISS;
        end else begin
            bus_cmd = BC_RDMISS;
        end
        bus_addr = victim_dirty ? {line_tag, req_idx} : cpu_addr;
    end

    // Issue on grant outside snoop cycles and give the state the line takes.
    always_comb begin
        fire       = bus_req && bus_gnt && !snp_vld;
        upd_tag_en = (bus_cmd != BC_WBACK);
        if (bus_cmd == BC_WBACK) begin
            upd_st = LN_INV;
        end else if (cpu_we) begin
            upd_st = LN_EXC;
        end else begin
            upd_st = LN_SHR;
        end
    end

endmodule

// File: rtl/snoop_bus_side.sv
// Snoop side: compares a snooped transaction with the line it indexes, flags intervention
// for a dirty owner and gives the state the line drops to.
// Assumes: snooped transactions come from other caches, never from this one.
module snoop_bus_side
    import snoop_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             snp_vld,
    input  logic             snp_wr,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_t         line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             snp_supply,
    output logic             upd_en,
    output line_st_t         upd_st
);
    logic held;

    // Detect a valid copy of the snooped block and work out the reaction.
    always_comb begin
        held       = snp_vld && (line_st != LN_INV) && (line_tag == snp_tag);
        snp_supply = held && (line_st == LN_EXC);
        upd_en     = held && (snp_wr || (line_st == LN_EXC));
        upd_st     = snp_wr ? LN_INV : LN_SHR;
    end

endmodule

// File: rtl/snoop_line_ctrl.sv
// Top of the snooping write-invalidate line controller: joins the tag/state array,
// the processor side and the snoop side. A snoop update takes the single array write
// port; a local issue can only occur in cycles without a snoop.
// Assumes: block addresses, direct mapping, one bus transaction per grant.
module snoop_line_ctrl
    import snoop_pkg::*;
#(
    parameter int AW    = 8,
    parameter int IDX_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    output logic          cpu_ready,
    output logic          bus_req,
    output logic [1:0]    bus_cmd,
    output logic [AW-1:0] bus_addr,
    input  logic          bus_gnt,
    input  logic          snp_vld,
    input  logic          snp_wr,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_supply
);
    localparam int TAG_W = AW - IDX_W;

    line_st_t         c_st, s_st, c_upd_st, s_upd_st, w_st;
    logic [TAG_W-1:0] c_tag, s_tag;
    logic             c_fire, c_tag_en, s_upd_en;
    logic             w_en, w_tag_en;
    logic [IDX_W-1:0] w_idx;
    bus_cmd_t         cmd_e;

    snoop_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_idx   (cpu_addr[IDX_W-1:0]),
        .ra_st    (c_st),
        .ra_tag   (c_tag),
        .rb_idx   (snp_addr[IDX_W-1:0]),
        .rb_st    (s_st),
        .rb_tag   (s_tag),
        .w_en     (w_en),
        .w_idx    (w_idx),
        .w_st     (w_st),
        .w_tag_en (w_tag_en),
        .w_tag    (cpu_addr[AW-1:IDX_W])
    );

    snoop_cpu_side #(.AW(AW), .IDX_W(IDX_W)) u_cpu (
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .line_st    (c_st),
        .line_tag   (c_tag),
        .snp_vld    (snp_vld),
        .bus_gnt    (bus_gnt),
        .cpu_ready  (cpu_ready),
        .bus_req    (bus_req),
        .bus_cmd    (cmd_e),
        .bus_addr   (bus_addr),
        .fire       (c_fire),
        .upd_st     (c_upd_st),
        .upd_tag_en (c_tag_en)
    );

    snoop_bus_side #(.TAG_W(TAG_W)) u_snp (
        .snp_vld    (snp_vld),
        .snp_wr     (snp_wr),
        .snp_tag    (snp_addr[AW-1:IDX_W]),
        .line_st    (s_st),
        .line_tag   (s_tag),
        .snp_supply (snp_supply),
        .upd_en     (s_upd_en),
        .upd_st     (s_upd_st)
    );

    // Route either the snoop update or the local issue onto the array write port.
    always_comb begin
        bus_cmd  = cmd_e;
        w_en     = s_upd_en || c_fire;
        w_idx    = s_upd_en ? snp_addr[IDX_W-1:0] : cpu_addr[IDX_W-1:0];
        w_st     = s_upd_en ? s_upd_st : c_upd_st;
        w_tag_en = !s_upd_en && c_tag_en;
    end

endmodule

// File: rtl/snoop_line_ctrl_chk.sv
// Checker for the line controller's port behaviour, attached to every instance by bind.
// Assumes: it sees the top's ports only.
module snoop_line_ctrl_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req,
    input logic          cpu_we,
    input logic [AW-1:0] cpu_addr,
    input logic          cpu_ready,
    input logic          bus_req,
    input logic [1:0]    bus_cmd,
    input logic [AW-1:0] bus_addr,
    input logic          bus_gnt,
    input logic          snp_vld,
    input logic          snp_supply
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |-> (!bus_req && !cpu_ready));

    // R6
    ready_xor_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_ready && bus_req));

    // R6
    hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_vld) |=>
        (!cpu_req || snp_vld || !$stable(cpu_addr) || !$stable(cpu_we) ||
         (bus_req && $stable(bus_cmd) && $stable(bus_addr))));

    // R3 R4
    miss_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && !snp_vld && (bus_cmd != 2'd3)) |=>
        (!cpu_req || snp_vld || !$stable(cpu_addr) || !$stable(cpu_we) || cpu_ready));

    // R5
    wback_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && !snp_vld && (bus_cmd == 2'd3)) |=>
        (!cpu_req || snp_vld || !$stable(cpu_addr) || !$stable(cpu_we) ||
         (bus_req && (bus_cmd != 2'd3) && (bus_addr == cpu_addr))));

    // R10
    snoop_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_vld |-> !cpu_ready);

    // R7 R8
    supply_needs_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> snp_vld);

endmodule

bind snoop_line_ctrl snoop_line_ctrl_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_ready  (cpu_ready),
    .bus_req    (bus_req),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .bus_gnt    (bus_gnt),
    .snp_vld    (snp_vld),
    .snp_supply (snp_supply)
);

// File: tb/snoop_line_ctrl_test.sv
// Bench: structured sweep of start state x operation x tag relation, then a long
// pseudo-random mix, compared against an arithmetic reference of the line states.
module snoop_line_ctrl_test;
    localparam int PERIOD = 10;
    localparam int AW     = 8;
    localparam int IDX_W  = 2;
    localparam int SETS   = 1 << IDX_W;
    localparam logic [5:0] TAG_A = 6'd0;
    localparam logic [5:0] TAG_B = 6'd37;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_ready, bus_req, snp_supply;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic          bus_gnt = 1'b0, snp_vld = 1'b0, snp_wr = 1'b0;
    logic [AW-1:0] snp_addr = '0;

    int n_chk = 0, n_fail = 0;
    int st_m [SETS];          // 0 Invalid, 1 Shared, 2 Exclusive
    logic [5:0] tg_m [SETS];
    logic [31:0] seed = 32'h1234_5678;

    always #(PERIOD/2) clk = ~clk;

    snoop_line_ctrl #(.AW(AW), .IDX_W(IDX_W)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_gnt(bus_gnt), .snp_vld(snp_vld), .snp_wr(snp_wr), .snp_addr(snp_addr),
        .snp_supply(snp_supply)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic logic [AW-1:0] mk(input logic [5:0] t, input int idx);
        return {t, 2'(idx)};
    endfunction

    // Reference: what the processor side should show for a request.
    task automatic expect_cpu(input logic we, input logic [AW-1:0] a,
                              output int hit, output int cmd, output int eaddr);
        int idx = int'(a[1:0]);
        bit tm = (tg_m[idx] == a[7:2]);
        hit = we ? int'(st_m[idx] == 2 && tm) : int'(st_m[idx] != 0 && tm);
        if (hit != 0) cmd = 0;
        else if (st_m[idx] == 2 && !tm) cmd = 3;
        else cmd = we ? 2 : 1;
        eaddr = (cmd == 3) ? int'({tg_m[idx], a[1:0]}) : int'(a);
    endtask

    task automatic apply_cpu(input int cmd, input logic [AW-1:0] a);
        int idx = int'(a[1:0]);
        if (cmd == 3) st_m[idx] = 0;
        else begin
            tg_m[idx] = a[7:2];
            st_m[idx] = (cmd == 2) ? 2 : 1;
        end
    endtask

    // Full processor access with one ungranted wait cycle per transaction.
    task automatic cpu_op(input logic we, input logic [AW-1:0] a);
        int hit, cmd, eaddr, c0, guard;
        guard = 0;
        @(negedge clk); cpu_req = 1'b1; cpu_we = we; cpu_addr = a;
        forever begin
            #2;
            expect_cpu(we, a, hit, cmd, eaddr);
            chk(hit != 0 ? "R2 ready on hit" : (cmd == 3 ? "R5 write-back cmd" : (we ? "R4 write-miss cmd" : "R3 read-miss cmd")),
                int'(bus_cmd), cmd);
            chk("R6 ready vs request", int'(cpu_ready), hit);
            if (hit != 0) break;
            chk("R5 R3 R4 bus address", int'(bus_addr), eaddr);
            c0 = int'(bus_cmd);
            @(negedge clk); #2;
            chk("R6 held without grant", int'({cpu_ready, bus_req, bus_cmd}), int'({1'b0, 1'b1, 2'(c0)}));
            bus_gnt = 1'b1;
            @(posedge clk); apply_cpu(cmd, a);
            @(negedge clk); bus_gnt = 1'b0;
            guard++;
            if (guard > 3) begin chk("R6 completion bound", guard, 3); break; end
        end
        @(negedge clk); cpu_req = 1'b0;
    endtask

    task automatic snoop_op(input logic wr, input logic [AW-1:0] a);
        int idx = int'(a[1:0]);
        bit held = (st_m[idx] != 0) && (tg_m[idx] == a[7:2]);
        int sup = int'(held && st_m[idx] == 2);
        @(negedge clk); snp_vld = 1'b1; snp_wr = wr; snp_addr = a;
        #2;
        chk(sup != 0 ? (wr ? "R8 supply on write miss" : "R7 supply on read miss") : "R9 no supply", int'(snp_supply), sup);
        @(posedge clk);
        if (held) begin
            if (wr) st_m[idx] = 0;
            else if (st_m[idx] == 2) st_m[idx] = 1;
        end
        @(negedge clk); snp_vld = 1'b0;
    endtask

    // Non-destructive probe of the line state for one address.
    task automatic probe(input logic [AW-1:0] a, input string req);
        int idx = int'(a[1:0]);
        bit tm = (tg_m[idx] == a[7:2]);
        int rd_hit, wr_hit;
        @(negedge clk); cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #2; rd_hit = int'(cpu_ready);
        cpu_we = 1'b1;
        #1; wr_hit = int'(cpu_ready);
        cpu_req = 1'b0;
        chk(req, rd_hit, int'(st_m[idx] != 0 && tm));
        chk(req, wr_hit, int'(st_m[idx] == 2 && tm));
    endtask

    task automatic probe_all(input string req);
        for (int s = 0; s < SETS; s++) begin
            probe(mk(TAG_A, s), req);
            probe(mk(TAG_B, s), req);
        end
    endtask

    task automatic do_op(input int kind, input logic [AW-1:0] a);
        case (kind)
            0: cpu_op(1'b0, a);
            1: cpu_op(1'b1, a);
            2: snoop_op(1'b0, a);
            default: snoop_op(1'b1, a);
        endcase
    endtask

    initial begin
        #(PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int s = 0; s < SETS; s++) begin st_m[s] = 0; tg_m[s] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state at the ports
        chk("R1 bus idle after reset", int'({bus_req, bus_cmd, snp_supply}), 0);
        probe_all("R1 all lines invalid");

        // Structured sweep: start state x operation x same/other tag on set 1
        for (int s0 = 0; s0 < 3; s0++) begin
            for (int op = 0; op < 4; op++) begin
                for (int other = 0; other < 2; other++) begin
                    snoop_op(1'b1, mk(TAG_A, 1));
                    snoop_op(1'b1, mk(TAG_B, 1));
                    if (s0 == 1) cpu_op(1'b0, mk(TAG_A, 1));
                    if (s0 == 2) cpu_op(1'b1, mk(TAG_A, 1));
                    do_op(op, mk(other != 0 ? TAG_B : TAG_A, 1));
                    probe(mk(TAG_A, 1), "R2 R3 R4 R5 R7 R8 R9 sweep state");
                    probe(mk(TAG_B, 1), "R2 R3 R4 R5 R7 R8 R9 sweep state");
                end
            end
        end

        // R10: snoop removes the dirty victim while a write-back waits on a grant
        cpu_op(1'b1, mk(TAG_A, 2));
        @(negedge clk); cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = mk(TAG_B, 2);
        #2; chk("R5 write-back before snoop", int'(bus_cmd), 3);
        snp_vld = 1'b1; snp_wr = 1'b1; snp_addr = mk(TAG_A, 2); bus_gnt = 1'b1;
        #1; chk("R10 supply in snoop cycle", int'(snp_supply), 1);
        chk("R10 no ready in snoop cycle", int'(cpu_ready), 0);
        @(posedge clk); st_m[2] = 0;
        @(negedge clk); snp_vld = 1'b0; bus_gnt = 1'b0;
        #2; chk("R10 write-back dropped", int'(bus_cmd), 2);
        chk("R10 miss address", int'(bus_addr), int'(mk(TAG_B, 2)));
        @(negedge clk); cpu_req = 1'b0;

        // R10: grant during an unrelated snoop is ignored
        @(negedge clk); cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = mk(TAG_B, 3);
        snp_vld = 1'b1; snp_wr = 1'b0; snp_addr = mk(TAG_A, 0); bus_gnt = 1'b1;
        @(negedge clk); snp_vld = 1'b0; bus_gnt = 1'b0;
        #2; chk("R10 grant ignored, still missing", int'({cpu_ready, bus_cmd}), 1);
        @(negedge clk); cpu_req = 1'b0;
        probe_all("R10 state after ignored grant");

        // Pseudo-random mix across all sets and both tags
        for (int i = 0; i < 300; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            do_op(int'(seed[17:16]), mk(seed[20] ? TAG_B : TAG_A, int'(seed[19:18])));
            if (i % 10 == 9) probe_all("R2 R3 R4 R5 R7 R8 R9 mixed state");
        end

        finish_run();
    end

endmodule